// File: doc/BRIEF.md
# SPI Master Transfer Delay Sequencer

This block times one SPI master transfer at the chip-select level. A one-cycle start request comes with two command bits. One bit enables a programmable lead delay. The other bit selects the kind of trailing delay. Alongside them come a 7-bit lead field, an 8-bit trail field and an 8-bit baud divisor, all taken from a register interface. On a start, the sequencer pulls chip select low and waits out the lead delay. It then clocks out a fixed-length word MSB first while it samples the input line. Chip select is then raised. The sequencer holds off for the trailing deselect interval before it reports completion.

All timing counts in system clocks. One serial-clock half period is the baud divisor, with zero treated as one. The trailing interval gives a slow peripheral, such as a serial converter, time to finish before the next select. Command inputs and fields are captured when a start is accepted. Later changes to them do not affect the transfer in flight.

Top module: `spi_xfer_sequencer`

## Requirements
- R1: After a synchronous reset, cs_n_o is 1, sclk_o is 0, busy_o is 0 and done_o is 0.
- R2: Each high phase and each low phase of sclk_o lasts H system clocks, where H is baud_div_i, or 1 when baud_div_i is 0.
- R3: When lead_en_i is 1 and lead_cnt_i is nonzero, chip select is low for exactly lead_cnt_i clocks before the first rising edge of sclk_o.
- R4: When lead_en_i is 0 or lead_cnt_i is 0, that lead interval is H clocks.
- R5: With trail_sel_i at 0, cs_n_o stays high for 17 clocks after it rises before done_o pulses.
- R6: With trail_sel_i at 1 and trail_cnt_i nonzero, that interval is 32 times trail_cnt_i clocks.
- R7: With trail_sel_i at 1 and trail_cnt_i at 0, that interval is 8192 clocks.
- R8: A transfer produces exactly WORD_W rising edges of sclk_o, all while cs_n_o is low. sclk_o is low whenever cs_n_o is high. The last low phase of H clocks ends when cs_n_o rises.
- R9: mosi_o shows bit WORD_W-k of tx_word_i at the k-th rising edge of sclk_o (MSB first). It changes only while sclk_o falls.
- R10: miso_i is sampled at each rising edge of sclk_o, and the first sample becomes the MSB. rx_word_o holds the assembled word on the done_o cycle and changes at no other time.
- R11: busy_o is high from the cycle after an accepted start until done_o. done_o is high for one cycle, and busy_o is low in that cycle.
- R12: A start request, or a change to the command and field inputs, has no effect while busy_o is high. Timing follows the values captured at the accepted start, and no second transfer begins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Transfer request, accepted when idle |
| lead_en_i | input | 1 | Enables the programmable lead delay |
| trail_sel_i | input | 1 | 0: standard trailing delay, 1: programmed trailing delay |
| lead_cnt_i | input | LEAD_W | Lead delay in system clocks |
| trail_cnt_i | input | TRAIL_W | Trailing delay in units of 32 system clocks |
| baud_div_i | input | BAUD_W | Serial clock half period in system clocks |
| tx_word_i | input | WORD_W | Word to send |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idle low |
| mosi_o | output | 1 | Serial data out |
| busy_o | output | 1 | Transfer or trailing delay in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rx_word_o | output | WORD_W | Received word |

## Verification
The hardest condition to reach is a start request, together with changed fields, arriving in the middle of a transfer. The request must leave the captured timing untouched. It must also start nothing once the trailing delay ends. The bench produces this by raising start and changing every field three cycles into selected transfers. It then measures the lead, phase and trailing intervals against the original settings and watches chip select stay high afterwards. The sweep covers divisors 0 to 3 against every lead and trail option. Separate runs cover the 8192-cycle zero-field case and the largest divisor and fields.

// File: rtl/spi_seq_pkg.sv
package spi_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_XFER  = 2'd2,
    ST_TRAIL = 2'd3
  } seq_state_e;

endpackage

// File: rtl/spi_seq_delay_calc.sv
module spi_seq_delay_calc #(
  parameter int LEAD_W     = 7,
  parameter int TRAIL_W    = 8,
  parameter int BAUD_W     = 8,
  parameter int CNT_W      = 15,
  parameter int STD_TRAIL  = 17,
  parameter int TRAIL_MULT = 32,
  parameter int ZERO_TRAIL = 8192
) (
  input  logic               lead_en_i,
  input  logic               trail_sel_i,
  input  logic [LEAD_W-1:0]  lead_cnt_i,
  input  logic [TRAIL_W-1:0] trail_cnt_i,
  input  logic [BAUD_W-1:0]  baud_div_i,
  output logic [CNT_W-1:0]   half_cyc_o,
  output logic [CNT_W-1:0]   lead_cyc_o,
  output logic [CNT_W-1:0]   trail_cyc_o
);

  logic [CNT_W-1:0] half_c;

  always_comb begin
    if (baud_div_i == '0) half_c = CNT_W'(1);
    else                  half_c = CNT_W'(baud_div_i);
  end

  always_comb begin
    if (lead_en_i && (lead_cnt_i != '0)) lead_cyc_o = CNT_W'(lead_cnt_i);
    else                                 lead_cyc_o = half_c;
  end

  always_comb begin
    if (!trail_sel_i)              trail_cyc_o = CNT_W'(STD_TRAIL);
    else if (trail_cnt_i == '0)    trail_cyc_o = CNT_W'(ZERO_TRAIL);
    else                           trail_cyc_o = CNT_W'(TRAIL_MULT) * CNT_W'(trail_cnt_i);
  end

  assign half_cyc_o = half_c;

endmodule

// File: rtl/spi_seq_timer.sv
module spi_seq_timer #(
  parameter int CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= load_val_i - CNT_W'(1);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/spi_seq_shifter.sv
module spi_seq_shifter #(
  parameter int WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [WORD_W-1:0] tx_word_i,
  input  logic              advance_i,
  input  logic              sample_i,
  input  logic              miso_i,
  output logic              mosi_o,
  output logic [WORD_W-1:0] rx_word_o
);

  logic [WORD_W-1:0] tx_sh_q;
  logic [WORD_W-1:0] rx_sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_sh_q <= '0;
    end else if (load_i) begin
      tx_sh_q <= tx_word_i;
    end else if (advance_i) begin
      tx_sh_q <= {tx_sh_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh_q <= '0;
    end else if (sample_i) begin
      rx_sh_q <= {rx_sh_q[WORD_W-2:0], miso_i};
    end
  end

  assign mosi_o    = tx_sh_q[WORD_W-1];
  assign rx_word_o = rx_sh_q;

endmodule

// File: rtl/spi_xfer_sequencer.sv
module spi_xfer_sequencer
  import spi_seq_pkg::*;
#(
  parameter int WORD_W     = 8,
  parameter int LEAD_W     = 7,
  parameter int TRAIL_W    = 8,
  parameter int BAUD_W     = 8,
  parameter int STD_TRAIL  = 17,
  parameter int TRAIL_MULT = 32,
  parameter int ZERO_TRAIL = 8192
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic               lead_en_i,
  input  logic               trail_sel_i,
  input  logic [LEAD_W-1:0]  lead_cnt_i,
  input  logic [TRAIL_W-1:0] trail_cnt_i,
  input  logic [BAUD_W-1:0]  baud_div_i,
  input  logic [WORD_W-1:0]  tx_word_i,
  input  logic               miso_i,
  output logic               cs_n_o,
  output logic               sclk_o,
  output logic               mosi_o,
  output logic               busy_o,
  output logic               done_o,
  output logic [WORD_W-1:0]  rx_word_o
);

  localparam int CNT_W = $clog2(ZERO_TRAIL + TRAIL_MULT * (2 ** TRAIL_W)
                                + (2 ** BAUD_W) + (2 ** LEAD_W) + STD_TRAIL);
  localparam int BIT_W = $clog2(WORD_W + 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  seq_state_e       state_q;
  logic             sclk_q;
  logic             cs_n_q;
  logic             busy_q;
  logic             done_q;
  logic [WORD_W-1:0] rx_out_q;
  logic [CNT_W-1:0] half_q;
  logic [CNT_W-1:0] trail_q;
  logic [BIT_W-1:0] bit_q;

  logic [CNT_W-1:0] half_c;
  logic [CNT_W-1:0] lead_c;
  logic [CNT_W-1:0] trail_c;

  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_zero;

  logic             sh_load;
  logic             sh_advance;
  logic             sh_sample;
  logic             sh_mosi;
  logic [WORD_W-1:0] sh_rx;

  logic             accept;
  logic             lead_end;
  logic             high_end;
  logic             low_end;
  logic             last_bit;

  spi_seq_delay_calc #(
    .LEAD_W     (LEAD_W),
    .TRAIL_W    (TRAIL_W),
    .BAUD_W     (BAUD_W),
    .CNT_W      (CNT_W),
    .STD_TRAIL  (STD_TRAIL),
    .TRAIL_MULT (TRAIL_MULT),
    .ZERO_TRAIL (ZERO_TRAIL)
  ) u_calc (
    .lead_en_i   (lead_en_i),
    .trail_sel_i (trail_sel_i),
    .lead_cnt_i  (lead_cnt_i),
    .trail_cnt_i (trail_cnt_i),
    .baud_div_i  (baud_div_i),
    .half_cyc_o  (half_c),
    .lead_cyc_o  (lead_c),
    .trail_cyc_o (trail_c)
  );

  spi_seq_timer #(
    .CNT_W (CNT_W)
  ) u_timer (
    .clk        (clk),
    .rst        (rst),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  spi_seq_shifter #(
    .WORD_W (WORD_W)
  ) u_shift (
    .clk       (clk),
    .rst       (rst),
    .load_i    (sh_load),
    .tx_word_i (tx_word_i),
    .advance_i (sh_advance),
    .sample_i  (sh_sample),
    .miso_i    (miso_i),
    .mosi_o    (sh_mosi),
    .rx_word_o (sh_rx)
  );

  // Event decode for the current cycle
  assign accept   = (state_q == ST_IDLE) && start_i;
  assign lead_end = (state_q == ST_LEAD) && tmr_zero;
  assign high_end = (state_q == ST_XFER) && tmr_zero && sclk_q;
  assign low_end  = (state_q == ST_XFER) && tmr_zero && !sclk_q;
  assign last_bit = (bit_q == LAST_BIT);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = half_q;
    if (accept) begin
      tmr_load = 1'b1;
      tmr_val  = lead_c;
    end else if (lead_end || high_end) begin
      tmr_load = 1'b1;
      tmr_val  = half_q;
    end else if (low_end) begin
      tmr_load = 1'b1;
      tmr_val  = last_bit ? trail_q : half_q;
    end
  end

  assign sh_load    = accept;
  assign sh_advance = high_end && !last_bit;
  assign sh_sample  = lead_end || (low_end && !last_bit);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      sclk_q   <= 1'b0;
      cs_n_q   <= 1'b1;
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rx_out_q <= '0;
      half_q   <= CNT_W'(1);
      trail_q  <= CNT_W'(STD_TRAIL);
      bit_q    <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_LEAD;
            cs_n_q  <= 1'b0;
            busy_q  <= 1'b1;
            half_q  <= half_c;
            trail_q <= trail_c;
            bit_q   <= '0;
          end
        end
        ST_LEAD: begin
          if (tmr_zero) begin
            state_q <= ST_XFER;
            sclk_q  <= 1'b1;
          end
        end
        ST_XFER: begin
          if (tmr_zero) begin
            if (sclk_q) begin
              sclk_q <= 1'b0;
            end else if (last_bit) begin
              cs_n_q  <= 1'b1;
              state_q <= ST_TRAIL;
            end else begin
              sclk_q <= 1'b1;
              bit_q  <= bit_q + BIT_W'(1);
            end
          end
        end
        ST_TRAIL: begin
          if (tmr_zero) begin
            state_q  <= ST_IDLE;
            busy_q   <= 1'b0;
            done_q   <= 1'b1;
            rx_out_q <= sh_rx;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_n_o    = cs_n_q;
  assign sclk_o    = sclk_q;
  assign mosi_o    = sh_mosi;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_word_o = rx_out_q;

endmodule

// File: rtl/spi_seq_checker.sv
module spi_seq_checker #(
  parameter int WORD_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n_o,
  input logic              sclk_o,
  input logic              mosi_o,
  input logic              busy_o,
  input logic              done_o,
  input logic [WORD_W-1:0] rx_word_o
);

  // R8: serial clock only toggles inside a selected window
  p_sclk_gated_r8: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  // R11: idle lines when not busy
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy_o |-> (cs_n_o && !sclk_o));

  // R11: completion is a single-cycle pulse
  p_done_single_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R11: busy ends exactly on the completion cycle
  p_done_ends_busy_r11: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (!busy_o && $past(busy_o)));

  // R11: chip select falls only with busy raised
  p_select_busy_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n_o) |-> busy_o);

  // R9: data holds across the rising edge and the high phase
  p_mosi_hold_rise_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk_o) |-> $stable(mosi_o));

  p_mosi_hold_high_r9: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(mosi_o));

  // R10: received word updates only on completion
  p_rx_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !$stable(rx_word_o) |-> done_o);

endmodule

bind spi_xfer_sequencer spi_seq_checker #(
  .WORD_W (WORD_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n_o    (cs_n_o),
  .sclk_o    (sclk_o),
  .mosi_o    (mosi_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .rx_word_o (rx_word_o)
);

// File: tb/spi_xfer_sequencer_tb.sv
module spi_xfer_sequencer_tb;

  localparam int CLK_PERIOD = 10;
  localparam int W          = 8;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_i = 1'b0;
  logic       lead_en_i = 1'b0;
  logic       trail_sel_i = 1'b0;
  logic [6:0] lead_cnt_i = '0;
  logic [7:0] trail_cnt_i = '0;
  logic [7:0] baud_div_i = '0;
  logic [W-1:0] tx_word_i = '0;
  logic       miso_i = 1'b0;
  logic       cs_n_o, sclk_o, mosi_o, busy_o, done_o;
  logic [W-1:0] rx_word_o;

  int n_tests = 0;
  int n_fail  = 0;
  int cycles  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_xfer_sequencer u_dut (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .lead_en_i   (lead_en_i),
    .trail_sel_i (trail_sel_i),
    .lead_cnt_i  (lead_cnt_i),
    .trail_cnt_i (trail_cnt_i),
    .baud_div_i  (baud_div_i),
    .tx_word_i   (tx_word_i),
    .miso_i      (miso_i),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .mosi_o      (mosi_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .rx_word_o   (rx_word_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic run_xfer(input bit en, input int lead, input bit sel, input int trail,
                          input int baud, input logic [W-1:0] tx, input logic [W-1:0] rxp,
                          input bit poke);
    int h_exp, l_exp, t_exp;
    int n, phase, rises, lead_m, half_bad, mosi_bad, busy_bad, trail_m;
    bit prev, seen, in_trail, fin;
    string lead_req, trail_req;
    h_exp = (baud == 0) ? 1 : baud;
    l_exp = (en && lead != 0) ? lead : h_exp;
    t_exp = !sel ? 17 : ((trail == 0) ? 8192 : 32 * trail);
    lead_req  = (en && lead != 0) ? "R3 lead" : "R4 lead";
    trail_req = !sel ? "R5 trail" : ((trail == 0) ? "R7 trail" : "R6 trail");

    @(negedge clk);
    lead_en_i   = en;
    lead_cnt_i  = 7'(lead);
    trail_sel_i = sel;
    trail_cnt_i = 8'(trail);
    baud_div_i  = 8'(baud);
    tx_word_i   = tx;
    miso_i      = rxp[W-1];
    start_i     = 1'b1;

    n = 0; phase = 0; rises = 0; lead_m = -1; half_bad = 0; mosi_bad = 0;
    busy_bad = 0; trail_m = 0; prev = 1'b0; seen = 1'b0; in_trail = 1'b0; fin = 1'b0;
    while (!fin) begin
      @(negedge clk);
      start_i = 1'b0;
      n++;
      if (poke && n == 3) begin
        // R12: request and new fields while busy
        start_i     = 1'b1;
        baud_div_i  = 8'(baud + 3);
        lead_cnt_i  = 7'(lead + 2);
        lead_en_i   = !en;
        trail_sel_i = !sel;
        trail_cnt_i = 8'(trail + 1);
        tx_word_i   = ~tx;
      end
      if (done_o) begin
        fin = 1'b1;
      end else begin
        if (!busy_o) busy_bad++;
        if (!cs_n_o) begin
          if (in_trail) busy_bad++;
          if (sclk_o != prev) begin
            if (!seen) lead_m = phase;
            else if (phase != h_exp) half_bad++;
            if (sclk_o) begin
              rises++;
              if (rises <= W && mosi_o != tx[W-rises]) mosi_bad++;
              seen = 1'b1;
            end
            phase = 1;
          end else begin
            phase++;
          end
          prev = sclk_o;
        end else begin
          if (!in_trail) begin
            in_trail = 1'b1;
            if (phase != h_exp) half_bad++;
          end
          if (sclk_o) half_bad++;
          trail_m++;
        end
        if (rises < W) miso_i = rxp[W-1-rises];
      end
    end

    chk(lead_m == l_exp, lead_req, lead_m, l_exp);
    chk(half_bad == 0, "R2 half period", half_bad, 0);
    chk(rises == W, "R8 edge count", rises, W);
    chk(mosi_bad == 0, "R9 mosi order", mosi_bad, 0);
    chk(trail_m == t_exp, trail_req, trail_m, t_exp);
    chk(rx_word_o == rxp, "R10 rx word", int'(rx_word_o), int'(rxp));
    chk(busy_bad == 0 && !busy_o, "R11 busy window", busy_bad, 0);
    @(negedge clk);
    chk(!done_o, "R11 done one cycle", int'(done_o), 0);
    chk(rx_word_o == rxp, "R10 rx hold", int'(rx_word_o), int'(rxp));
    if (poke) begin
      int stray = 0;
      for (int i = 0; i < 12; i++) begin
        if (!cs_n_o || busy_o) stray++;
        @(negedge clk);
      end
      chk(stray == 0, "R12 no second transfer", stray, 0);
    end
  endtask

  initial begin
    int leads [4];
    leads[0] = 0; leads[1] = 1; leads[2] = 5; leads[3] = 127;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n_o === 1'b1 && sclk_o === 1'b0, "R1 reset lines", int'({cs_n_o, sclk_o}), 2);
    chk(busy_o === 1'b0 && done_o === 1'b0, "R1 reset status", int'({busy_o, done_o}), 0);

    for (int b = 0; b < 4; b++) begin
      for (int lc = 0; lc < 5; lc++) begin
        for (int tc = 0; tc < 3; tc++) begin
          bit en;
          int ld;
          en = (lc != 4);
          ld = (lc == 4) ? 9 : leads[lc];
          run_xfer(en, ld, (tc != 0), (tc == 2) ? 3 : 1, b,
                   8'(8'hA5 ^ (b * 37 + lc * 11 + tc)), 8'(8'h3C + b * 17 + lc * 5 + tc),
                   1'b0);
        end
      end
    end

    // R7: zero trail field with select set
    run_xfer(1'b0, 0, 1'b1, 0, 2, 8'h81, 8'h7E, 1'b0);
    // R6, R2, R3: largest fields
    run_xfer(1'b1, 127, 1'b1, 255, 255, 8'hC3, 8'h96, 1'b0);
    // R12: start and field changes mid-transfer
    run_xfer(1'b1, 4, 1'b0, 0, 2, 8'h5A, 8'hF0, 1'b1);
    run_xfer(1'b0, 0, 1'b1, 2, 1, 8'h0F, 8'h01, 1'b1);
    run_xfer(1'b1, 6, 1'b1, 0, 3, 8'hE7, 8'h80, 1'b1);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule